// File: doc/BRIEF.md
# Table-Lookup Arithmetic Unit

This block performs a two-operand arithmetic function without any arithmetic datapath. Each operand arrives as a short index into the codebook of its own variable. The result is another codebook index. It is read from a constant table that holds one two-operand function. The table address is the concatenation of the two operand indices, so a table has 2^(A_W+B_W) entries of R_W bits each. Several such tables sit side by side, and one of them serves each lookup.

A request can choose its table in two ways. A direct lookup carries the table number alongside the operands. A set command loads a sticky active-table register, and every later active lookup reads that table until another set command or a reset. Requests use a valid/ready handshake. Results come out one cycle after acceptance through a registered valid/ready port, and they stay in place until the consumer takes them.

Top module: `qlut_alu`

## Requirements
- R1: The mode field encodes 0 as direct lookup, 1 as set active table, 2 as active lookup and 3 as reserved. A direct lookup with table id t below NUM_TABLES returns f_t(a,b) with res_err low. The functions are: table 0 gives min(a+b, 2^R_W-1); table 1 gives |a-b|; table 2 gives max(a,b); table 3 gives (a*b) >> A_W, truncated to R_W bits.
- R2: A set command with an in-range id loads the active-table register and produces no result (res_valid stays low after it unless another lookup follows).
- R3: An active lookup reads the table held in the active-table register and ignores req_table. The register keeps its value until the next in-range set command.
- R4: After a synchronous active-low reset, res_valid is low, req_ready is high and the active table is table 0.
- R5: A lookup accepted on a clock edge shows res_valid high, with its result, in the cycle after that edge.
- R6: While res_valid is high and res_ready is low, res_idx and res_err hold steady, req_ready is low and no new request is taken.
- R7: A direct lookup whose table id is NUM_TABLES or above returns index 0 with res_err high. A set command with such an id is ignored and leaves the active table unchanged.
- R8: A request in the reserved mode returns index 0 with res_err high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_mode | input | 2 | 0 direct, 1 set table, 2 active lookup, 3 reserved |
| req_table | input | TID_W | Table id for direct lookup or set command |
| req_a | input | A_W | First operand codebook index |
| req_b | input | B_W | Second operand codebook index |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_idx | output | R_W | Result codebook index |
| res_err | output | 1 | Table id out of range or reserved mode |

## Verification
The bench goes after saturation at the top of the add table and the product table's largest operands. A design with a wrong address split or a wrong function would return other indices there. It checks that an active lookup ignores the table id on the request. It also checks that a bad set id leaves the active table alone, so a design that loaded truncated ids would read the wrong table. It resets the block in the middle of a run with a non-zero active table, which exposes a register that keeps stale state. A stalled consumer with a waiting second request shows whether a design overwrites or drops a held result.

// File: rtl/qlut_pkg.sv
// Shared definitions for the table-lookup arithmetic unit.
// Holds the request mode encoding and the function that fills each table.
// Assumes operand and result widths of 8 bits or less.
package qlut_pkg;

    typedef enum logic [1:0] {
        QM_DIRECT = 2'd0,
        QM_SET    = 2'd1,
        QM_ACTIVE = 2'd2,
        QM_RSVD   = 2'd3
    } qmode_e;

    // Value of table fsel at operands (a, b), masked to r_w bits.
    function automatic int unsigned qlut_func(
        input int unsigned fsel,
        input int unsigned a,
        input int unsigned b,
        input int unsigned a_w,
        input int unsigned r_w
    );
        int unsigned rmax;
        int unsigned v;
        rmax = (32'd1 << r_w) - 32'd1;
        case (fsel)
            0: v = ((a + b) > rmax) ? rmax : (a + b);
            1: v = (a > b) ? (a - b) : (b - a);
            2: v = (a > b) ? a : b;
            3: v = (a * b) >> a_w;
            default: v = a ^ b;
        endcase
        return v & rmax;
    endfunction

endpackage

// File: rtl/qlut_rom.sv
// One constant function table, read synchronously.
// The address is {a, b}. The output register changes only when rd_en is high,
// so it holds the last read value for as long as the caller needs it.
module qlut_rom
    import qlut_pkg::*;
#(
    parameter int unsigned FUNC_SEL = 0,
    parameter int unsigned A_W      = 4,
    parameter int unsigned B_W      = 4,
    parameter int unsigned R_W      = 4
) (
    input  logic                 clk,
    input  logic                 rd_en,
    input  logic [A_W+B_W-1:0]   rd_addr,
    output logic [R_W-1:0]       rd_q
);
    localparam int unsigned AW    = A_W + B_W;
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned BMASK = (1 << B_W) - 1;

    logic [R_W-1:0] mem [DEPTH];

    // Fill the table from the package function (constant contents).
    initial begin
        for (int unsigned i = 0; i < DEPTH; i++) begin
            mem[i] = R_W'(qlut_func(FUNC_SEL, i >> B_W, i & BMASK, A_W, R_W));
        end
    end

    // Registered read, enabled only for an accepted lookup into this table.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/qlut_ctrl.sv
// Request decode, active-table register and result-valid tracking.
// It picks the table for each lookup, flags bad ids and reserved modes, and
// holds result state until the consumer accepts it. Assumes TID_W >= SEL_W.
module qlut_ctrl
    import qlut_pkg::*;
#(
    parameter int unsigned NUM_TABLES = 4,
    parameter int unsigned TID_W      = 3,
    parameter int unsigned SEL_W      = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [1:0]             req_mode,
    input  logic [TID_W-1:0]       req_table,
    input  logic                   res_ready,
    output logic [NUM_TABLES-1:0]  rd_en,
    output logic                   res_valid,
    output logic                   res_err,
    output logic [SEL_W-1:0]       res_sel
);
    logic [SEL_W-1:0] active_q;
    logic [TID_W-1:0] eff_tid;
    logic             accept;
    logic             is_lookup;
    logic             is_set;
    logic             in_range;
    logic             req_in_range;
    qmode_e           mode;

    assign mode      = qmode_e'(req_mode);
    assign req_ready = !res_valid || res_ready;
    assign accept    = req_valid && req_ready;
    assign is_lookup = (mode == QM_DIRECT) || (mode == QM_ACTIVE);
    assign is_set    = (mode == QM_SET);

    // Choose the table id: the sticky register for active lookups, else the request.
    always_comb begin
        eff_tid = req_table;
        if (mode == QM_ACTIVE) begin
            eff_tid = TID_W'(active_q);
        end
    end

    assign in_range     = 32'(eff_tid) < NUM_TABLES;
    assign req_in_range = 32'(req_table) < NUM_TABLES;

    // One read enable per table, high only for a valid accepted lookup.
    generate
        for (genvar t = 0; t < NUM_TABLES; t++) begin : g_en
            assign rd_en[t] = accept && is_lookup && in_range
                              && (32'(eff_tid) == t);
        end
    endgenerate

    // Sticky active-table register; bad ids are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (accept && is_set && req_in_range) begin
            active_q <= req_table[SEL_W-1:0];
        end
    end

    // Result state: loaded on accepted non-set requests, cleared when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            res_sel   <= '0;
        end else if (accept && !is_set) begin
            res_valid <= 1'b1;
            res_err   <= !(is_lookup && in_range);
            res_sel   <= (is_lookup && in_range) ? eff_tid[SEL_W-1:0] : '0;
        end else if (res_ready) begin
            res_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/qlut_alu.sv
// Top of the table-lookup arithmetic unit.
// It builds the address {a, b}, instantiates one ROM per function table and
// selects the registered output of the table that the last lookup used.
// Assumes A_W, B_W and R_W are each 8 or less.
module qlut_alu
    import qlut_pkg::*;
#(
    parameter int unsigned NUM_TABLES = 4,
    parameter int unsigned TID_W      = 3,
    parameter int unsigned A_W        = 4,
    parameter int unsigned B_W        = 4,
    parameter int unsigned R_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_mode,
    input  logic [TID_W-1:0]  req_table,
    input  logic [A_W-1:0]    req_a,
    input  logic [B_W-1:0]    req_b,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [R_W-1:0]    res_idx,
    output logic              res_err
);
    localparam int unsigned SEL_W = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1;
    localparam int unsigned AW    = A_W + B_W;

    logic [NUM_TABLES-1:0] rd_en;
    logic [SEL_W-1:0]      res_sel;
    logic [AW-1:0]         addr;
    logic [R_W-1:0]        rom_q [NUM_TABLES];

    assign addr = {req_a, req_b};

    qlut_ctrl #(
        .NUM_TABLES (NUM_TABLES),
        .TID_W      (TID_W),
        .SEL_W      (SEL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_mode  (req_mode),
        .req_table (req_table),
        .res_ready (res_ready),
        .rd_en     (rd_en),
        .res_valid (res_valid),
        .res_err   (res_err),
        .res_sel   (res_sel)
    );

    // One constant table per function.
    generate
        for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
            qlut_rom #(
                .FUNC_SEL (t),
                .A_W      (A_W),
                .B_W      (B_W),
                .R_W      (R_W)
            ) u_rom (
                .clk     (clk),
                .rd_en   (rd_en[t]),
                .rd_addr (addr),
                .rd_q    (rom_q[t])
            );
        end
    endgenerate

    // Output select; errors and idle cycles give index 0.
    always_comb begin
        res_idx = '0;
        if (res_valid && !res_err) begin
            res_idx = rom_q[res_sel];
        end
    end

endmodule

// File: rtl/qlut_alu_chk.sv
// Property checker for qlut_alu, attached by bind below.
// It observes only the top-level ports.
module qlut_alu_chk #(
    parameter int unsigned NUM_TABLES = 4,
    parameter int unsigned TID_W      = 3,
    parameter int unsigned A_W        = 4,
    parameter int unsigned B_W        = 4,
    parameter int unsigned R_W        = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_mode,
    input logic [TID_W-1:0] req_table,
    input logic             res_valid,
    input logic             res_ready,
    input logic [R_W-1:0]   res_idx,
    input logic             res_err
);
    // R4
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode != 2'd1) |=> res_valid);

    // R2
    set_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == 2'd1) |=> !res_valid);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_idx) && $stable(res_err)));

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |-> (res_idx == '0));

    // R7
    bad_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == 2'd0 && 32'(req_table) >= NUM_TABLES)
        |=> (res_valid && res_err));

    // R8
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == 2'd3) |=> (res_valid && res_err));

endmodule

bind qlut_alu qlut_alu_chk #(
    .NUM_TABLES (NUM_TABLES),
    .TID_W      (TID_W),
    .A_W        (A_W),
    .B_W        (B_W),
    .R_W        (R_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mode  (req_mode),
    .req_table (req_table),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_idx   (res_idx),
    .res_err   (res_err)
);

// File: tb/sim_qlut_alu.sv
module sim_qlut_alu;
    localparam int NT = 4;
    localparam int RW = 4;
    localparam int AW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_mode = 2'd0;
    logic [2:0] req_table = 3'd0;
    logic [3:0] req_a = 4'd0;
    logic [3:0] req_b = 4'd0;
    logic       res_valid;
    logic       res_ready = 1'b1;
    logic [3:0] res_idx;
    logic       res_err;

    int n_chk = 0;
    int n_bad = 0;
    int model_active = 0;

    always #5 clk = ~clk;

    qlut_alu u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_table(req_table), .req_a(req_a), .req_b(req_b),
        .res_valid(res_valid), .res_ready(res_ready), .res_idx(res_idx),
        .res_err(res_err)
    );

    // {mode[12:11], table[10:8], a[7:4], b[3:0]}
    localparam logic [12:0] VEC [16] = '{
        {2'd0, 3'd0, 4'd9,  4'd8 },   // R1 saturating add
        {2'd0, 3'd0, 4'd3,  4'd4 },   // R1 add
        {2'd0, 3'd1, 4'd2,  4'd11},   // R1 abs diff
        {2'd0, 3'd2, 4'd5,  4'd12},   // R1 max
        {2'd0, 3'd3, 4'd15, 4'd15},   // R1 product top
        {2'd0, 3'd5, 4'd1,  4'd1 },   // R7 bad id
        {2'd2, 3'd3, 4'd3,  4'd3 },   // R3/R4 active = 0
        {2'd1, 3'd3, 4'd0,  4'd0 },   // R2 set 3
        {2'd2, 3'd0, 4'd7,  4'd9 },   // R3
        {2'd2, 3'd1, 4'd10, 4'd2 },   // R3 req_table ignored
        {2'd1, 3'd6, 4'd0,  4'd0 },   // R7 bad set
        {2'd2, 3'd0, 4'd8,  4'd8 },   // R7 still table 3
        {2'd1, 3'd1, 4'd0,  4'd0 },   // R2 set 1
        {2'd2, 3'd0, 4'd4,  4'd13},   // R3
        {2'd3, 3'd0, 4'd6,  4'd6 },   // R8 reserved
        {2'd0, 3'd7, 4'd6,  4'd6 }    // R7 bad id
    };

    function automatic int ref_val(input int f, input int a, input int b);
        int m;
        m = (1 << RW) - 1;
        if (f == 0) return (a + b > m) ? m : a + b;
        if (f == 1) return (a > b) ? a - b : b - a;
        if (f == 2) return (a > b) ? a : b;
        return ((a * b) >> AW) & m;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one request at a negedge; sample at the negedge after acceptance.
    task automatic issue(input logic [1:0] m, input logic [2:0] t,
                         input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_table = t; req_a = a; req_b = b;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_lookup(input string tag, input int f, input int a, input int b);
        check({tag, " valid"}, int'(res_valid), 1);
        if (f < 0) begin
            check({tag, " err"}, int'(res_err), 1);
            check({tag, " idx"}, int'(res_idx), 0);
        end else begin
            check({tag, " err"}, int'(res_err), 0);
            check({tag, " idx"}, int'(res_idx), ref_val(f, a, b));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R4 reset state
        check("R4 res_valid", int'(res_valid), 0);
        check("R4 req_ready", int'(req_ready), 1);

        // Vector walk
        for (int i = 0; i < 16; i++) begin
            int m, t, a, b, f;
            m = int'(VEC[i][12:11]); t = int'(VEC[i][10:8]);
            a = int'(VEC[i][7:4]);   b = int'(VEC[i][3:0]);
            issue(VEC[i][12:11], VEC[i][10:8], VEC[i][7:4], VEC[i][3:0]);
            if (m == 1) begin
                check("R2 set gives no result", int'(res_valid), 0);
                if (t < NT) model_active = t;
            end else begin
                if (m == 3) f = -1;
                else if (m == 2) f = model_active;
                else f = (t < NT) ? t : -1;
                expect_lookup(m == 3 ? "R8" : (m == 2 ? "R3" : (f < 0 ? "R7" : "R1")), f, a, b);
            end
        end

        // R5: idle cycle empties the result, the next lookup shows in one cycle
        @(negedge clk);
        check("R5 idle", int'(res_valid), 0);
        issue(2'd0, 3'd2, 4'd1, 4'd14);
        expect_lookup("R5", 2, 1, 14);

        // R4: reset mid-run returns active table to 0
        issue(2'd1, 3'd2, 4'd0, 4'd0);
        issue(2'd2, 3'd0, 4'd5, 4'd6);
        expect_lookup("R3 pre-reset", 2, 5, 6);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R4 valid after reset", int'(res_valid), 0);
        issue(2'd2, 3'd3, 4'd5, 4'd6);
        expect_lookup("R4 active is 0", 0, 5, 6);

        // R6: stalled consumer holds result and blocks a waiting request
        @(negedge clk); res_ready = 1'b0;
        issue(2'd0, 3'd1, 4'd3, 4'd12);
        expect_lookup("R6 first", 1, 3, 12);
        check("R6 ready low", int'(req_ready), 0);
        req_valid = 1'b1; req_mode = 2'd0; req_table = 3'd0; req_a = 4'd1; req_b = 4'd2;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check("R6 held idx", int'(res_idx), ref_val(1, 3, 12));
            check("R6 ready stays low", int'(req_ready), 0);
        end
        res_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        expect_lookup("R6 second", 0, 1, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule